// File: doc/BRIEF.md
# Address Region Remap Unit

This block rewrites request addresses through a small table of programmable windows. Each window has an enable, a size code, a base alias, a target, a burst-type bit and an output-port bit. The window size runs from 2 MB to 128 MB in powers of two. When an address falls inside an enabled window, the high address bits are replaced by the window's target and the offset inside the window is kept. The window's burst and port bits are sent out with the new address.

The table is loaded through a plain register port, one 32-bit word per window at consecutive indices. Words are written on a clock edge and read back combinationally. The translation path is purely combinational from request address to outputs. Software must finish a window's fields before it sets that window's enable.

Top module: `region_remap`

## Requirements
- R1: There are four configuration words, indices 0 to 3. With `cfg_we` high, `cfg_wdata` is stored at index `cfg_waddr` on the rising clock edge. `cfg_rdata` always shows the stored word at index `cfg_raddr`.
- R2: A synchronous active-high `rst` clears all four words to zero. With every word at zero, no request is remapped.
- R3: The word layout is as follows. Bits [7:0] hold the base, which is request-address bits [28:21]. Bits [10:8] hold the size code. Bit 15 is the enable. Bits [26:16] hold the target, which is output-address bits [31:21]. Bit 28 is the port select: 0 selects port 1 and 1 selects port 2. Bit 31 is the burst type: 0 is wrapping and 1 is incrementing. All other bits are stored and read back but have no effect.
- R4: Size codes 1 to 7 give windows of 2 MB, 4 MB, 8 MB, 16 MB, 32 MB, 64 MB and 128 MB. For size code s, a window matches when request bits [28:20+s] equal the same bits of its base (base placed at bit 21). Request bits [31:29] take no part in the match.
- R5: A window with its enable at 0, or with size code 0, never matches.
- R6: On a match with size code s, `out_addr` takes bits [31:20+s] from the target (target placed at bit 21) and bits [19+s:0] from the request.
- R7: When several enabled windows match, the window with the lowest index is used.
- R8: When no window matches, `out_addr` equals `req_addr`, and `out_hit`, `out_incr` and `out_port_sel` are all 0.
- R9: On a match, `out_hit` is 1, `out_region` gives the index of the window used, and `out_incr` and `out_port_sel` copy that window's burst and port bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 2 | Index of the word to write |
| cfg_wdata | input | 32 | Data to write |
| cfg_raddr | input | 2 | Index of the word to read |
| cfg_rdata | output | 32 | Stored word at `cfg_raddr` |
| req_addr | input | 32 | Incoming request address |
| out_addr | output | 32 | Translated address |
| out_hit | output | 1 | A window matched |
| out_region | output | 2 | Index of the matching window |
| out_incr | output | 1 | Burst type: 1 incrementing, 0 wrapping |
| out_port_sel | output | 1 | Port select: 1 port 2, 0 port 1 |

## Verification
The bench sets up two overlapping windows of different sizes. A design with the priority reversed would return the higher index. A design that applied one window's size to the other would compare or splice at the wrong bit. Requests with bits [31:29] set catch a compare that wrongly includes those bits, because such a design would miss them. A window that is enabled but has size code 0 sits at base zero, and a design that ignores the zero code would claim address zero. Clearing the lower window's enable must hand its addresses to the larger window, and a stale enable would keep the old target.

// File: rtl/region_remap_pkg.sv
package region_remap_pkg;

    localparam int ADDR_W   = 32;
    localparam int GRAN_LSB = 21;
    localparam int ALIAS_W  = 29;
    localparam int BASE_W   = ALIAS_W - GRAN_LSB;
    localparam int TGT_W    = ADDR_W - GRAN_LSB;
    localparam int SIZE_W   = 3;
    localparam int WORD_W   = 32;

    localparam int F_BASE_LSB = 0;
    localparam int F_SIZE_LSB = 8;
    localparam int F_EN_BIT   = 15;
    localparam int F_TGT_LSB  = 16;
    localparam int F_PORT_BIT = 28;
    localparam int F_BURST_BIT = 31;

    typedef enum logic { BURST_WRAP = 1'b0, BURST_INCR = 1'b1 } burst_e;
    typedef enum logic { PORT_ONE = 1'b0, PORT_TWO = 1'b1 } port_e;

    typedef struct packed {
        logic               en;
        logic [SIZE_W-1:0]  size;
        logic [BASE_W-1:0]  base;
        logic [TGT_W-1:0]   tgt;
        burst_e             burst;
        port_e              port;
    } win_cfg_t;

    typedef struct packed {
        logic               hit;
        logic [ADDR_W-1:0]  addr;
        burst_e             burst;
        port_e              port;
    } win_res_t;

    function automatic win_cfg_t unpack_word(input logic [WORD_W-1:0] w);
        win_cfg_t c;
        c.en    = w[F_EN_BIT];
        c.size  = w[F_SIZE_LSB +: SIZE_W];
        c.base  = w[F_BASE_LSB +: BASE_W];
        c.tgt   = w[F_TGT_LSB +: TGT_W];
        c.burst = burst_e'(w[F_BURST_BIT]);
        c.port  = port_e'(w[F_PORT_BIT]);
        return c;
    endfunction

    // Offset mask for a window of 2^(20+size) bytes.
    function automatic logic [ADDR_W-1:0] offset_mask(input logic [SIZE_W-1:0] size);
        logic [ADDR_W-1:0] one;
        one = {{(ADDR_W-1){1'b0}}, 1'b1};
        return (one << (GRAN_LSB - 1 + int'(size))) - one;
    endfunction

endpackage

// File: rtl/region_remap_regs.sv
module region_remap_regs
    import region_remap_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = $clog2(NUM_WIN)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IDX_W-1:0]       waddr,
    input  logic [WORD_W-1:0]      wdata,
    input  logic [IDX_W-1:0]       raddr,
    output logic [WORD_W-1:0]      rdata,
    output logic [NUM_WIN-1:0][WORD_W-1:0] words
);

    logic [NUM_WIN-1:0][WORD_W-1:0] store_q;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                store_q[g] <= '0;
            end else if (we && (waddr == IDX_W'(g))) begin
                store_q[g] <= wdata;
            end
        end
    end

    assign rdata = store_q[raddr];
    assign words = store_q;

endmodule

// File: rtl/region_remap_win.sv
module region_remap_win
    import region_remap_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] addr,
    output win_res_t          res
);

    win_cfg_t          cfg;
    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] cmp_mask;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] tgt_full;
    logic [ADDR_W-1:0] alias_mask;

    always_comb begin
        cfg        = unpack_word(word);
        offs       = offset_mask(cfg.size);
        alias_mask = {{(ADDR_W-ALIAS_W){1'b0}}, {ALIAS_W{1'b1}}};
        cmp_mask   = alias_mask & ~offs;
        base_full  = {{(ADDR_W-ALIAS_W){1'b0}}, cfg.base, {GRAN_LSB{1'b0}}};
        tgt_full   = {cfg.tgt, {GRAN_LSB{1'b0}}};
        res.hit    = cfg.en && (cfg.size != '0) &&
                     (((addr ^ base_full) & cmp_mask) == '0);
        res.addr   = (tgt_full & ~offs) | (addr & offs);
        res.burst  = cfg.burst;
        res.port   = cfg.port;
    end

endmodule

// File: rtl/region_remap_pick.sv
module region_remap_pick
    import region_remap_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = $clog2(NUM_WIN)
) (
    input  win_res_t [NUM_WIN-1:0] cand,
    input  logic [ADDR_W-1:0]      addr,
    output win_res_t               sel,
    output logic [IDX_W-1:0]       sel_idx
);

    always_comb begin
        sel.hit   = 1'b0;
        sel.addr  = addr;
        sel.burst = BURST_WRAP;
        sel.port  = PORT_ONE;
        sel_idx   = '0;
        // Walk from the top so the lowest index is applied last and wins.
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (cand[i].hit) begin
                sel     = cand[i];
                sel_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/region_remap.sv
module region_remap
    import region_remap_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_waddr,
    input  logic [WORD_W-1:0]  cfg_wdata,
    input  logic [IDX_W-1:0]   cfg_raddr,
    output logic [WORD_W-1:0]  cfg_rdata,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_hit,
    output logic [IDX_W-1:0]   out_region,
    output logic               out_incr,
    output logic               out_port_sel
);

    logic [NUM_WIN-1:0][WORD_W-1:0] cfg_words;
    win_res_t [NUM_WIN-1:0]         cand;
    win_res_t                       chosen;

    region_remap_regs #(.NUM_WIN(NUM_WIN)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .waddr (cfg_waddr),
        .wdata (cfg_wdata),
        .raddr (cfg_raddr),
        .rdata (cfg_rdata),
        .words (cfg_words)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        region_remap_win win_i (
            .word (cfg_words[g]),
            .addr (req_addr),
            .res  (cand[g])
        );
    end

    region_remap_pick #(.NUM_WIN(NUM_WIN)) pick_i (
        .cand    (cand),
        .addr    (req_addr),
        .sel     (chosen),
        .sel_idx (out_region)
    );

    assign out_addr     = chosen.addr;
    assign out_hit      = chosen.hit;
    assign out_incr     = chosen.burst == BURST_INCR;
    assign out_port_sel = chosen.port == PORT_TWO;

endmodule

// File: rtl/region_remap_chk.sv
module region_remap_chk
    import region_remap_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W = $clog2(NUM_WIN)
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           cfg_we,
    input logic [IDX_W-1:0]               cfg_waddr,
    input logic [WORD_W-1:0]              cfg_wdata,
    input logic [ADDR_W-1:0]              req_addr,
    input logic [ADDR_W-1:0]              out_addr,
    input logic                           out_hit,
    input logic [IDX_W-1:0]               out_region,
    input logic                           out_incr,
    input logic                           out_port_sel,
    input logic [NUM_WIN-1:0][WORD_W-1:0] words
);

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> words[$past(cfg_waddr)] == $past(cfg_wdata)); // R1

    AST_RESET_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_hit); // R2

    AST_HIT_NEEDS_LIVE_WIN: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (words[out_region][F_EN_BIT] &&
                     words[out_region][F_SIZE_LSB +: SIZE_W] != '0)); // R5

    AST_GRANULE_KEPT: assert property (@(posedge clk) disable iff (rst)
        out_addr[GRAN_LSB-2:0] == req_addr[GRAN_LSB-2:0]); // R6

    AST_MISS_PASSES: assert property (@(posedge clk) disable iff (rst)
        !out_hit |-> (out_addr == req_addr && !out_incr && !out_port_sel)); // R8

    AST_ATTR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (out_incr == words[out_region][F_BURST_BIT] &&
                     out_port_sel == words[out_region][F_PORT_BIT])); // R9

endmodule

bind region_remap region_remap_chk #(.NUM_WIN(NUM_WIN)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_waddr    (cfg_waddr),
    .cfg_wdata    (cfg_wdata),
    .req_addr     (req_addr),
    .out_addr     (out_addr),
    .out_hit      (out_hit),
    .out_region   (out_region),
    .out_incr     (out_incr),
    .out_port_sel (out_port_sel),
    .words        (cfg_words)
);

// File: tb/region_remap_tb_top.sv
module region_remap_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_waddr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] req_addr = '0;
    logic [31:0] out_addr;
    logic        out_hit;
    logic [1:0]  out_region;
    logic        out_incr;
    logic        out_port_sel;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    region_remap dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .req_addr(req_addr), .out_addr(out_addr), .out_hit(out_hit),
        .out_region(out_region), .out_incr(out_incr), .out_port_sel(out_port_sel)
    );

    // Word per R3: base[7:0], size[10:8], en bit15, target[26:16], port bit28, burst bit31.
    function automatic logic [31:0] mk_word(bit en, int size, int base, int tgt, bit port, bit burst);
        logic [31:0] w;
        w = '0;
        w[7:0]   = base[7:0];
        w[10:8]  = size[2:0];
        w[15]    = en;
        w[26:16] = tgt[10:0];
        w[28]    = port;
        w[31]    = burst;
        return w;
    endfunction

    localparam logic [31:0] W0 = 32'h1400_8110; // en, size1, base 0x10, tgt 0x400, port1, wrap
    localparam logic [31:0] W1 = 32'h8600_8310; // en, size3, base 0x10, tgt 0x600, port0, incr
    localparam logic [31:0] W2 = 32'h9100_8780; // en, size7, base 0x80, tgt 0x100, port1, incr
    localparam logic [31:0] W3 = 32'h0000_8000; // en, size0, base 0

    // {req, exp_addr, exp_hit, exp_region, exp_incr, exp_port}
    localparam int NV = 6;
    localparam logic [68:0] VEC [NV] = '{
        {32'h0212_3456, 32'h8012_3456, 1'b1, 2'd0, 1'b0, 1'b1},
        {32'h0234_5678, 32'hC034_5678, 1'b1, 2'd1, 1'b1, 1'b0},
        {32'h1234_5678, 32'h2234_5678, 1'b1, 2'd2, 1'b1, 1'b1},
        {32'hE212_3456, 32'h8012_3456, 1'b1, 2'd0, 1'b0, 1'b1},
        {32'h0000_1000, 32'h0000_1000, 1'b0, 2'd0, 1'b0, 1'b0},
        {32'h0400_0000, 32'h0400_0000, 1'b0, 2'd0, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_out(input string req, input logic [31:0] ea, input bit eh,
                             input logic [1:0] er, input bit ei, input bit ep);
        logic [36:0] act;
        logic [36:0] exp;
        act = {out_addr, out_hit, (out_hit ? out_region : 2'd0), out_incr, out_port_sel};
        exp = {ea, eh, er, ei, ep};
        check(act == exp, req, 64'(act), 64'(exp));
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R2: reset state
        for (int i = 0; i < 4; i++) begin
            cfg_raddr = 2'(i); #1;
            check(cfg_rdata == 32'h0, "R2 reset word", 64'(cfg_rdata), 64'h0);
        end
        req_addr = 32'h0000_0000; #1;
        check_out("R2 no hit after reset", 32'h0, 1'b0, 2'd0, 1'b0, 1'b0);

        // R3: local encoder agrees with constant words
        check(mk_word(1, 3, 8'h10, 11'h600, 0, 1) == W1, "R3 encoding", 64'(mk_word(1, 3, 8'h10, 11'h600, 0, 1)), 64'(W1));

        wr(2'd0, W0); wr(2'd1, W1); wr(2'd2, W2); wr(2'd3, W3);
        // R1: readback
        cfg_raddr = 2'd2; #1;
        check(cfg_rdata == W2, "R1 readback w2", 64'(cfg_rdata), 64'(W2));
        cfg_raddr = 2'd1; #1;
        check(cfg_rdata == W1, "R1 readback w1", 64'(cfg_rdata), 64'(W1));

        // R4 R6 R7 R8 R9 R5: vector walk
        for (int v = 0; v < NV; v++) begin
            req_addr = VEC[v][68:37]; #1;
            check_out($sformatf("R4/R6/R7/R8/R9/R5 vec%0d", v), VEC[v][36:5], VEC[v][4],
                      VEC[v][3:2], VEC[v][1], VEC[v][0]);
        end

        // R7: clear enable of window 0, its addresses fall to window 1
        wr(2'd0, W0 & ~32'h0000_8000);
        req_addr = 32'h0212_3456; #1;
        check_out("R7 fallback to window 1", 32'hC012_3456, 1'b1, 2'd1, 1'b1, 1'b0);
        // R5: disabled word still reads back
        cfg_raddr = 2'd0; #1;
        check(cfg_rdata == (W0 & ~32'h0000_8000), "R5 disabled word kept", 64'(cfg_rdata), 64'(W0 & ~32'h0000_8000));

        // R5: size 0 with enable never hits, and 0x00000000 passes through
        req_addr = 32'h0000_0000; #1;
        check_out("R5 size zero no match", 32'h0, 1'b0, 2'd0, 1'b0, 1'b0);

        // R4: top of 128MB window 2 still hits, just past it misses
        req_addr = 32'h17FF_FFFF; #1;
        check_out("R4 window top", 32'h27FF_FFFF, 1'b1, 2'd2, 1'b1, 1'b1);
        req_addr = 32'h1800_0000; #1;
        check_out("R4 past window", 32'h1800_0000, 1'b0, 2'd0, 1'b0, 1'b0);

        // R2: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        req_addr = 32'h1234_5678; #1;
        check_out("R2 reset clears windows", 32'h1234_5678, 1'b0, 2'd0, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule